// File: doc/BRIEF.md
# Banked Memory Map Decoder

This block sits between an 8-bit processor with a 16-bit address bus and two memories: a cartridge ROM of up to 32 pages of 16 KB, and an 8 KB work RAM. Every memory cycle is steered to one of them. The lower three quarters of the CPU address space form three 16 KB ROM windows. Each window shows one cartridge page, chosen by its own page register, and the block widens the CPU address into a 19-bit physical ROM address. The top quarter is the work RAM. Only the low 13 address bits reach the RAM, so the 8 KB appears twice in that quarter.

The page registers are loaded by CPU writes to the last four bytes of the address space. Such a write also goes on to the RAM, so the RAM holds a copy of every value written. Software reads that copy back at either of its two mirrored addresses. The first kilobyte of window 0 always reads cartridge page 0, whatever the window-0 register holds. This keeps the reset and interrupt entry code reachable at all times.

The chip selects and addresses are combinational from the bus inputs. The page registers change on the clock edge at which a register write is present.

Top module: `banked_mmap_dec`

## Requirements
- R1: `rom_sel` is 1 exactly when `mem_req` and `rd_en` are 1 and `cpu_addr` is in 0x0000–0xBFFF. `rom_sel` and `ram_sel` are never 1 together.
- R2: `ram_sel` is 1 exactly when `mem_req` is 1, `cpu_addr` is in 0xC000–0xFFFF, and `rd_en` or `wr_en` is 1.
- R3: During a ROM read, `rom_addr[18:14]` holds the page register of window `cpu_addr[15:14]` (window 0, 1 or 2), and `rom_addr[13:0]` equals `cpu_addr[13:0]`.
- R4: For `cpu_addr` in 0x0000–0x03FF, `rom_addr[18:14]` is 0, whatever the window-0 page register holds.
- R5: `ram_addr` equals `cpu_addr[12:0]`, so 0xC000+n and 0xE000+n reach the same RAM byte for any n below 0x2000.
- R6: A write cycle to 0xFFFD, 0xFFFE or 0xFFFF loads `cpu_wdata[4:0]` into the page register of window 0, 1 or 2. The new page applies to reads from the next clock cycle on. Bits 7:5 are dropped.
- R7: A write to 0xFFFC changes none of the page registers.
- R8: A write to 0xFFFC–0xFFFF also asserts `ram_sel` with `ram_addr` 0x1FFC–0x1FFF. The same RAM bytes are read back at 0xDFFC–0xDFFF.
- R9: After reset, the page registers of windows 0, 1 and 2 hold 0, 1 and 2.
- R10: A write to 0x0000–0xBFFF asserts no select and changes no page register.
- R11: With `mem_req` at 0, or with neither strobe active, no select is asserted and no page register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the page registers |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_addr | input | 16 | CPU address bus |
| cpu_wdata | input | 8 | CPU write data |
| mem_req | input | 1 | Memory cycle in progress, active high |
| rd_en | input | 1 | Read strobe, active high |
| wr_en | input | 1 | Write strobe, active high |
| rom_sel | output | 1 | Cartridge ROM chip select, active high |
| ram_sel | output | 1 | Work RAM chip select, active high |
| rom_addr | output | 19 | Physical cartridge address (page and offset) |
| ram_addr | output | 13 | Work RAM address |

## Verification
The only internal state is the three page registers. A wrong value shows at the ports on the first ROM read of the affected window after the faulty load: the top five bits of `rom_addr` differ. This happens one cycle after a register write at the earliest. A fault in the fixed first kilobyte, or in RAM mirroring, is purely combinational and shows on the same cycle as the access. A full address sweep is run under several page configurations and after stray writes, so every window and boundary is seen under each one.

// File: rtl/mmap_pkg.sv
package mmap_pkg;
    localparam int CPU_AW   = 16;
    localparam int DATA_W   = 8;
    localparam int PAGE_W   = 5;
    localparam int WIN_AW   = 14;
    localparam int FIXED_AW = 10;
    localparam int RAM_AW   = 13;
    localparam int N_WIN    = 3;
    localparam int ROM_AW   = PAGE_W + WIN_AW;

    typedef logic [N_WIN-1:0][PAGE_W-1:0] page_set_t;

    typedef enum logic [1:0] {
        WIN_0   = 2'd0,
        WIN_1   = 2'd1,
        WIN_2   = 2'd2,
        WIN_RAM = 2'd3
    } win_e;
endpackage

// File: rtl/mmap_region_dec.sv
module mmap_region_dec
    import mmap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CPU_AW-1:0] cpu_addr,
    input  logic              mem_req,
    input  logic              rd_en,
    input  logic              wr_en,
    output logic              rom_sel,
    output logic              ram_sel
);
    win_e win;

    always_comb begin
        win     = win_e'(cpu_addr[CPU_AW-1 -: 2]);
        rom_sel = 1'b0;
        ram_sel = 1'b0;
        unique case (win)
            WIN_0, WIN_1, WIN_2: rom_sel = mem_req && rd_en;
            WIN_RAM:             ram_sel = mem_req && (rd_en || wr_en);
            default: ;
        endcase
    end

    p_sel_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(rom_sel && ram_sel));
    p_rom_read_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rom_sel |-> (rd_en && mem_req));
    p_idle_no_sel_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_req || (!rd_en && !wr_en)) |-> (!rom_sel && !ram_sel));
    p_ram_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ram_sel |-> (rd_en || wr_en));
endmodule

// File: rtl/mmap_bank_regs.sv
module mmap_bank_regs
    import mmap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CPU_AW-1:0] cpu_addr,
    input  logic [PAGE_W-1:0] wdata_lo,
    input  logic              mem_req,
    input  logic              wr_en,
    output page_set_t         page_q
);
    localparam logic [CPU_AW-3:0] REG_BLOCK = '1;

    logic reg_wr;
    assign reg_wr = mem_req && wr_en && (cpu_addr[CPU_AW-1:2] == REG_BLOCK);

    for (genvar w = 0; w < N_WIN; w++) begin : g_page
        localparam logic [1:0]        SLOT    = 2'(w + 1);
        localparam logic [PAGE_W-1:0] RST_VAL = PAGE_W'(w);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                page_q[w] <= RST_VAL;
            else if (reg_wr && cpu_addr[1:0] == SLOT)
                page_q[w] <= wdata_lo;
        end

        p_page_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_wr && cpu_addr[1:0] == SLOT) |=> (page_q[w] == $past(wdata_lo)));
    end

    p_ctrl_no_effect_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && cpu_addr[1:0] == 2'd0) |=> $stable(page_q));
    p_no_write_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_wr |=> $stable(page_q));
endmodule

// File: rtl/mmap_addr_gen.sv
module mmap_addr_gen
    import mmap_pkg::*;
(
    input  logic [CPU_AW-1:0] cpu_addr,
    input  page_set_t         page_q,
    output logic [ROM_AW-1:0] rom_addr,
    output logic [RAM_AW-1:0] ram_addr
);
    localparam int HI_W = WIN_AW - FIXED_AW;

    logic [1:0]        win;
    logic              fixed_area;
    logic [PAGE_W-1:0] page;

    always_comb begin
        win        = cpu_addr[CPU_AW-1 -: 2];
        fixed_area = (win == 2'd0) && (cpu_addr[WIN_AW-1:FIXED_AW] == HI_W'(0));
        if (fixed_area || win == 2'd3)
            page = '0;
        else
            page = page_q[win];
        rom_addr = {page, cpu_addr[WIN_AW-1:0]};
        ram_addr = cpu_addr[RAM_AW-1:0];
    end
endmodule

// File: rtl/banked_mmap_dec.sv
module banked_mmap_dec
    import mmap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       cpu_addr,
    input  logic [7:0]        cpu_wdata,
    input  logic              mem_req,
    input  logic              rd_en,
    input  logic              wr_en,
    output logic              rom_sel,
    output logic              ram_sel,
    output logic [18:0]       rom_addr,
    output logic [12:0]       ram_addr
);
    page_set_t page_q;
    logic      unused_hi_data;

    assign unused_hi_data = ^cpu_wdata[DATA_W-1:PAGE_W];

    mmap_region_dec u_region (
        .clk      (clk),
        .rst_n    (rst_n),
        .cpu_addr (cpu_addr),
        .mem_req  (mem_req),
        .rd_en    (rd_en),
        .wr_en    (wr_en),
        .rom_sel  (rom_sel),
        .ram_sel  (ram_sel)
    );

    mmap_bank_regs u_banks (
        .clk      (clk),
        .rst_n    (rst_n),
        .cpu_addr (cpu_addr),
        .wdata_lo (cpu_wdata[PAGE_W-1:0]),
        .mem_req  (mem_req),
        .wr_en    (wr_en),
        .page_q   (page_q)
    );

    mmap_addr_gen u_addr (
        .cpu_addr (cpu_addr),
        .page_q   (page_q),
        .rom_addr (rom_addr),
        .ram_addr (ram_addr)
    );

    p_fixed_page_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rom_sel && cpu_addr[15:10] == 6'd0) |-> (rom_addr[18:14] == 5'd0));
    p_ram_mirror_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ram_sel |-> (ram_addr == cpu_addr[12:0]));
    p_offset_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rom_sel |-> (rom_addr[13:0] == cpu_addr[13:0]));
endmodule

// File: tb/banked_mmap_dec_tb.sv
module banked_mmap_dec_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        mem_req = 1'b0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic        rom_sel, ram_sel;
    logic [18:0] rom_addr;
    logic [12:0] ram_addr;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;
    logic [4:0] exp_pg [3];

    always #2.5 clk = ~clk;

    banked_mmap_dec dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .mem_req(mem_req), .rd_en(rd_en), .wr_en(wr_en),
        .rom_sel(rom_sel), .ram_sel(ram_sel), .rom_addr(rom_addr), .ram_addr(ram_addr)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s addr=%h actual=%h expected=%h", tag, cpu_addr, act, exp);
        end
    endtask

    // Read sweep over the full space: R1, R3, R4, R2, R5
    task automatic read_sweep();
        for (int a = 0; a < 65536; a++) begin
            cpu_addr = 16'(a); mem_req = 1'b1; rd_en = 1'b1; wr_en = 1'b0;
            #1;
            if (a < 32'hC000) begin
                logic [4:0] pg;
                pg = (a < 32'h400) ? 5'd0 : exp_pg[a >> 14];
                check(a < 32'h400 ? "R4" : "R3 R1",
                      {rom_sel, ram_sel, 11'd0, rom_addr},
                      {1'b1, 1'b0, 11'd0, pg, 14'(a)});
            end else begin
                check("R5 R2", {rom_sel, ram_sel, 17'd0, ram_addr},
                      {1'b0, 1'b1, 17'd0, 13'(a)});
            end
        end
        mem_req = 1'b0; rd_en = 1'b0;
    endtask

    task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; mem_req = 1'b1; wr_en = 1'b1; rd_en = 1'b0;
        #1;
        if (a >= 16'hC000)
            check("R8 R2", {rom_sel, ram_sel, 3'd0, ram_addr}, {1'b0, 1'b1, 3'd0, a[12:0]});
        else
            check("R10", {30'd0, rom_sel, ram_sel}, 32'd0);
        @(negedge clk);
        mem_req = 1'b0; wr_en = 1'b0;
        if (a == 16'hFFFD) exp_pg[0] = d[4:0];
        if (a == 16'hFFFE) exp_pg[1] = d[4:0];
        if (a == 16'hFFFF) exp_pg[2] = d[4:0];
    endtask

    task automatic check_pages(input string tag);
        @(negedge clk);
        mem_req = 1'b1; rd_en = 1'b1; wr_en = 1'b0;
        for (int w = 0; w < 3; w++) begin
            cpu_addr = 16'(w * 16'h4000 + 16'h0555);
            #1;
            check(tag, {27'd0, rom_addr[18:14]}, {27'd0, exp_pg[w]});
        end
        mem_req = 1'b0; rd_en = 1'b0;
    endtask

    initial begin
        exp_pg[0] = 5'd0; exp_pg[1] = 5'd1; exp_pg[2] = 5'd2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R11 reset idle", {30'd0, rom_sel, ram_sel}, 32'd0);
        check_pages("R9");
        read_sweep();

        // R6: page loads, upper data bits dropped
        bus_write(16'hFFFD, 8'hFF);
        bus_write(16'hFFFE, 8'hB1);
        bus_write(16'hFFFF, 8'h45);
        check_pages("R6");
        // R7: control byte write leaves pages alone
        bus_write(16'hFFFC, 8'h1E);
        check_pages("R7");
        read_sweep();

        // R8: register copies read back at low mirror
        @(negedge clk);
        mem_req = 1'b1; rd_en = 1'b1;
        for (int k = 0; k < 4; k++) begin
            cpu_addr = 16'hDFFC + 16'(k);
            #1;
            check("R8 mirror", {18'd0, ram_sel, ram_addr}, {18'd0, 1'b1, 13'h1FFC + 13'(k)});
        end
        mem_req = 1'b0; rd_en = 1'b0;

        // R10: ROM writes ignored, including ones aimed at register-like offsets
        bus_write(16'h3FFD, 8'h0A);
        bus_write(16'h7FFE, 8'h0B);
        bus_write(16'hBFFF, 8'h0C);
        check_pages("R10");

        // R11: write strobe without mem_req to a register
        @(negedge clk);
        cpu_addr = 16'hFFFD; cpu_wdata = 8'h07; wr_en = 1'b1; mem_req = 1'b0;
        #1;
        check("R11 nosel", {30'd0, rom_sel, ram_sel}, 32'd0);
        @(negedge clk);
        wr_en = 1'b0;
        check_pages("R11 pages");
        // R11: mem_req without any strobe, sampled over the space
        for (int a = 0; a < 65536; a += 257) begin
            cpu_addr = 16'(a); mem_req = 1'b1; rd_en = 1'b0; wr_en = 1'b0;
            #1;
            check("R11 nostrobe", {30'd0, rom_sel, ram_sel}, 32'd0);
        end
        mem_req = 1'b0;

        bus_write(16'hFFFD, 8'h09);
        bus_write(16'hFFFE, 8'h1E);
        bus_write(16'hFFFF, 8'h00);
        read_sweep();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                #900000;
                n_cmp++; n_bad++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule